// File: doc/BRIEF.md
# Sequenced Real-Time Clock Update Core

This block keeps calendar time in seven system-side registers: seconds, minutes, hours, weekday, day of month, month and two-digit year. All seven hold packed BCD. When a slow once-per-second tick rises, the core starts an update. The seconds register advances first. If it wraps, a carry moves to the next register up, one register per fixed-length time slot. The length of a slot is derived from the fast clock rate, so each slot lasts 0.5 ms at the real clock rate.

Software never reads the working registers directly. Once the ripple has finished, the whole updated set is copied in a single clock edge into a user-side shadow bank, and a one-cycle publish pulse is raised. The shadow bank is read through a byte-wide, address-decoded read port, so a reader sees either the complete old time or the complete new time.

A mode input selects how the publish is timed. In variable mode, the publish follows the last register step, so the delay grows with the length of the ripple. In fixed mode, the publish always waits for seven slots, so successive publishes stay exactly one tick period apart. A synchronous load port presets the working registers.

Top module: `rtc_ripple_core`

## Requirements
- R1: After reset the shadow bank reads sec 00, min 00, hour 00, weekday 01, date 01, month 01, year 00, and `publish` is low. Read addresses 0 to 6 select sec, min, hour, weekday, date, month and year in that order, and address 7 reads 8'h00.
- R2: A rising edge on `tick_1hz` starts an update only when no update is running. A rising edge that arrives during an update has no effect: it produces no extra publish and no extra increment.
- R3: The ripple steps through sec, min, hour, weekday, date, month, year, in that order, with one register per slot. The next register is stepped only when the one below it wrapped, except that the weekday step always hands the hour carry on to the date. Sec and min wrap from 59 to 00, and hour wraps from 23 to 00.
- R4: Weekday wraps from 07 to 01, month wraps from 12 to 01, and year wraps from 99 to 00. Rolling past 23:59:59 on December 31 touches all seven registers.
- R5: The date wraps to 01 after the last day of its month. That last day is 30 for months 04, 06, 09 and 11, 31 for every other month except February, and for February 29 when the BCD year is a multiple of 4, otherwise 28.
- R6: With `fixed_mode` = 0, `publish` is first seen high (SYNC_STAGES + 1) + n × SLOT_CYCLES clock edges after the tick input rises, where n is the number of registers touched.
- R7: With `fixed_mode` = 1, that delay is always (SYNC_STAGES + 1) + 7 × SLOT_CYCLES, whatever the ripple length.
- R8: `publish` lasts exactly one cycle. The shadow bank changes only on the edge that raises `publish`, and all seven bytes change together on that edge.
- R9: A load writes `load_data` (byte i goes to read address i) into the working registers only; the shadow bank keeps its value until the next publish. `fixed_mode` is sampled when an update starts and is held fixed until that update ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock that drives the slot timer and all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | Once-per-second tick; it is synchronised inside the core |
| fixed_mode | input | 1 | 1 selects a constant seven-slot publish delay, 0 selects a ripple-length delay |
| load_en | input | 1 | Synchronous preset strobe for the working registers |
| load_data | input | 56 | Preset value, seven BCD bytes with sec in the low byte |
| rd_addr | input | 3 | Shadow bank byte select |
| rd_data | output | 8 | Selected shadow byte |
| publish | output | 1 | One-cycle pulse raised on the edge that copies the working set into the shadow bank |

## Verification
On every cycle, the assertions check several properties:

- The publish pulse lasts exactly one cycle.
- The shadow bank changes only on the edge that publishes.
- At most one working register changes per edge.
- Seconds and hours stay in their legal BCD ranges.
- Each edge detected on the tick lasts a single cycle.
- A latency counter matches the publish against the slot count of the selected mode.

Calendar correctness needs the bench's scenarios, since only they compare full register sets against an independent integer model. This covers month ends in leap and common years, the year-end rollover, and the time-to-publish measured from the tick input. The same applies to ignoring a second tick, to mode sampling at start, and to the load port leaving the shadow bank untouched.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NREG = 7;

  localparam logic [2:0] IX_SEC  = 3'd0;
  localparam logic [2:0] IX_MIN  = 3'd1;
  localparam logic [2:0] IX_HOUR = 3'd2;
  localparam logic [2:0] IX_WDAY = 3'd3;
  localparam logic [2:0] IX_DATE = 3'd4;
  localparam logic [2:0] IX_MON  = 3'd5;
  localparam logic [2:0] IX_YEAR = 3'd6;

  typedef logic [7:0] bcd_t;
  typedef logic [NREG-1:0][7:0] bank_t;

  typedef enum logic {ST_IDLE, ST_RUN} seq_state_t;

  localparam bank_t RESET_BANK = {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

  // add one to a packed BCD byte (caller guarantees no 99 overflow)
  function automatic bcd_t bcd_inc(bcd_t v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // BCD year is a multiple of 4: even tens need ones 0/4/8, odd tens need 2/6
  function automatic logic year_is_leap(bcd_t yr);
    if (!yr[4]) return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
  endfunction

  function automatic bcd_t month_last_day(bcd_t mon, bcd_t yr);
    case (mon)
      8'h02:                      return year_is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic bcd_t reg_limit(logic [2:0] idx, bcd_t mon, bcd_t yr);
    case (idx)
      IX_SEC, IX_MIN: return 8'h59;
      IX_HOUR:        return 8'h23;
      IX_WDAY:        return 8'h07;
      IX_DATE:        return month_last_day(mon, yr);
      IX_MON:         return 8'h12;
      default:        return 8'h99;
    endcase
  endfunction

  function automatic bcd_t reg_floor(logic [2:0] idx);
    case (idx)
      IX_WDAY, IX_DATE, IX_MON: return 8'h01;
      default:                  return 8'h00;
    endcase
  endfunction

  // returns {wrapped, new value} for one register step
  function automatic logic [8:0] step_reg(logic [2:0] idx, bcd_t v, bcd_t mon, bcd_t yr);
    bcd_t lim;
    lim = reg_limit(idx, mon, yr);
    if (v == lim) return {1'b1, reg_floor(idx)};
    else          return {1'b0, bcd_inc(v)};
  endfunction

endpackage

// File: rtl/rtc_tick_edge.sv
module rtc_tick_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_rise
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], tick_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign tick_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

  // R2
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise);
endmodule

// File: rtl/rtc_slot_timer.sv
module rtc_slot_timer #(
  parameter int SLOT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic slot_end
);
  localparam int CW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (run) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  assign slot_end = run && (cnt_q == LAST);
endmodule

// File: rtl/rtc_ripple_seq.sv
module rtc_ripple_seq
  import rtc_pkg::*;
#(
  parameter int SLOT_CYCLES = 1000
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick_rise,
  input  logic  fixed_mode,
  input  logic  load_en,
  input  bank_t load_bank,
  input  logic  slot_end,
  output logic  start,
  output logic  running,
  output logic  publish_now,
  output bank_t bank_next
);
  localparam int LW = $clog2(NREG * SLOT_CYCLES + 1);

  seq_state_t  state_q;
  bank_t       sys_q;
  logic [2:0]  idx_q;
  logic [2:0]  slot_num_q;
  logic        active_q;
  logic        mode_q;
  logic [LW-1:0] lat_cnt_q;

  logic        step;
  logic [8:0]  stepped;
  logic        more;
  logic        ripple_last;
  logic [NREG-1:0] touch;

  assign running = (state_q == ST_RUN);
  assign start   = (state_q == ST_IDLE) && tick_rise && !load_en;
  assign step    = running && active_q && slot_end;
  assign stepped = step_reg(idx_q, sys_q[idx_q], sys_q[IX_MON], sys_q[IX_YEAR]);
  // weekday always passes the hour carry on to the date
  assign more        = (idx_q == IX_WDAY) || (stepped[8] && idx_q != IX_YEAR);
  assign ripple_last = step && !more;
  assign publish_now = running && slot_end &&
                       (mode_q ? (slot_num_q == 3'(NREG - 1)) : ripple_last);

  always_comb begin
    bank_next = sys_q;
    if (step) bank_next[idx_q] = stepped[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      sys_q      <= RESET_BANK;
      idx_q      <= '0;
      slot_num_q <= '0;
      active_q   <= 1'b0;
      mode_q     <= 1'b0;
      lat_cnt_q  <= '0;
    end else if (load_en) begin
      sys_q    <= load_bank;
      state_q  <= ST_IDLE;
      active_q <= 1'b0;
    end else begin
      sys_q <= bank_next;
      if (start) begin
        state_q    <= ST_RUN;
        idx_q      <= '0;
        slot_num_q <= '0;
        active_q   <= 1'b1;
        mode_q     <= fixed_mode;
        lat_cnt_q  <= '0;
      end else if (running) begin
        lat_cnt_q <= lat_cnt_q + 1'b1;
        if (slot_end) slot_num_q <= slot_num_q + 3'd1;
        if (step) begin
          if (more) idx_q <= idx_q + 3'd1;
          else      active_q <= 1'b0;
        end
        if (publish_now) state_q <= ST_IDLE;
      end
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_touch
    assign touch[i] = (bank_next[i] != sys_q[i]);
  end

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(touch));
  // R3
  sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> (sys_q[IX_SEC] <= 8'h59 && sys_q[IX_HOUR] <= 8'h23) || $past(load_en));
  // R7
  fixed_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (publish_now && mode_q) |-> int'(lat_cnt_q) == NREG * SLOT_CYCLES - 1);
  // R6
  var_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (publish_now && !mode_q) |-> int'(lat_cnt_q) == (int'(idx_q) + 1) * SLOT_CYCLES - 1);
endmodule

// File: rtl/rtc_ripple_core.sv
module rtc_ripple_core
  import rtc_pkg::*;
#(
  parameter int CLK_HZ      = 2_000_000,
  parameter int SLOT_US     = 500,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_1hz,
  input  logic                fixed_mode,
  input  logic                load_en,
  input  logic [8*NREG-1:0]   load_data,
  input  logic [2:0]          rd_addr,
  output logic [7:0]          rd_data,
  output logic                publish
);
  localparam int SLOT_CYCLES = (CLK_HZ / 1000) * SLOT_US / 1000;

  logic  tick_rise;
  logic  start;
  logic  running;
  logic  slot_end;
  logic  publish_now;
  bank_t bank_next;
  bank_t shadow_q;

  rtc_tick_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_1hz), .tick_rise(tick_rise)
  );

  rtc_slot_timer #(.SLOT_CYCLES(SLOT_CYCLES)) u_slot (
    .clk(clk), .rst_n(rst_n), .restart(start), .run(running), .slot_end(slot_end)
  );

  rtc_ripple_seq #(.SLOT_CYCLES(SLOT_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick_rise(tick_rise), .fixed_mode(fixed_mode),
    .load_en(load_en), .load_bank(bank_t'(load_data)), .slot_end(slot_end),
    .start(start), .running(running), .publish_now(publish_now), .bank_next(bank_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= RESET_BANK;
      publish  <= 1'b0;
    end else begin
      publish <= publish_now;
      if (publish_now) shadow_q <= bank_next;
    end
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == 3'(i)) rd_data = shadow_q[i];
  end

  // R8
  pub_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    publish |=> !publish);
  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shadow_q) |-> publish);
endmodule

// File: tb/rtc_ripple_core_test.sv
`timescale 1ns/1ps
module rtc_ripple_core_test;
  localparam int SLOT = 4;
  localparam int SYNC_LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_1hz = 1'b0;
  logic        fixed_mode = 1'b0;
  logic        load_en = 1'b0;
  logic [55:0] load_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        publish;

  int checks = 0;
  int failures = 0;

  rtc_ripple_core #(.CLK_HZ(8000), .SLOT_US(500), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .fixed_mode(fixed_mode),
    .load_en(load_en), .load_data(load_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .publish(publish)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int days_in(int mo, int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] pack_time(int s, int mi, int h, int wd, int d, int mo, int yr);
    return {to_bcd(yr), to_bcd(mo), to_bcd(d), to_bcd(wd), to_bcd(h), to_bcd(mi), to_bcd(s)};
  endfunction

  // integer model of one tick; n = registers touched
  function automatic logic [55:0] model_next(input logic [55:0] b, output int n);
    int s, mi, h, wd, d, mo, yr;
    s = from_bcd(b[7:0]);   mi = from_bcd(b[15:8]);  h = from_bcd(b[23:16]);
    wd = from_bcd(b[31:24]); d = from_bcd(b[39:32]); mo = from_bcd(b[47:40]);
    yr = from_bcd(b[55:48]);
    n = 1; s++;
    if (s == 60) begin
      s = 0; n = 2; mi++;
      if (mi == 60) begin
        mi = 0; n = 3; h++;
        if (h == 24) begin
          h = 0; n = 5; wd = (wd == 7) ? 1 : wd + 1; d++;
          if (d > days_in(mo, yr)) begin
            d = 1; n = 6; mo++;
            if (mo > 12) begin mo = 1; n = 7; yr = (yr + 1) % 100; end
          end
        end
      end
    end
    return pack_time(s, mi, h, wd, d, mo, yr);
  endfunction

  task automatic read_bank(output logic [55:0] b);
    for (int i = 0; i < 7; i++) begin
      rd_addr = 3'(i);
      #0.5;
      b[8*i +: 8] = rd_data;
    end
    rd_addr = 3'd0;
  endtask

  task automatic load_bank(input logic [55:0] b);
    @(negedge clk);
    load_en = 1'b1; load_data = b;
    @(negedge clk);
    load_en = 1'b0;
  endtask

  task automatic run_tick(input logic [55:0] start_b, input logic mode, input bit flip,
                          input bit retick, input string req);
    logic [55:0] old_b, exp_b, got_b;
    int n, lat, exp_lat;
    bit seen, mixed;
    exp_b = model_next(start_b, n);
    exp_lat = mode ? SYNC_LAT + 7 * SLOT : SYNC_LAT + n * SLOT;
    @(negedge clk);
    read_bank(old_b);
    fixed_mode = mode; tick_1hz = 1'b1;
    lat = 0; seen = 0; mixed = 0;
    while (!seen && lat < 200) begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (lat == 6) tick_1hz = 1'b0;
      if (flip && lat == 5) fixed_mode = ~mode;
      if (retick && lat == 12) tick_1hz = 1'b1;
      if (retick && lat == 16) tick_1hz = 1'b0;
      if (publish) seen = 1;
      else if (rd_data != old_b[7:0]) mixed = 1;
    end
    tick_1hz = 1'b0;
    check(seen, req, "publish seen", 64'(seen), 64'd1);
    check(lat == exp_lat, mode ? "R7" : "R6", "publish latency", 64'(lat), 64'(exp_lat));
    check(!mixed, "R8", "shadow stable before publish", 64'(mixed), 64'd0);
    read_bank(got_b);
    check(got_b == exp_b, req, "published time", 64'(got_b), 64'(exp_b));
    @(negedge clk);
    check(publish == 1'b0, "R8", "publish one cycle", 64'(publish), 64'd0);
    if (retick) begin
      bit extra = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (publish) extra = 1;
      end
      check(!extra, "R2", "no publish from tick during update", 64'(extra), 64'd0);
      read_bank(got_b);
      check(got_b == exp_b, "R2", "single increment", 64'(got_b), 64'(exp_b));
    end
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [55:0] rand_time();
    int s, mi, h, wd, d, mo, yr, dim;
    s  = ($urandom % 2 != 0) ? 59 : int'($urandom % 60);
    mi = ($urandom % 2 != 0) ? 59 : int'($urandom % 60);
    h  = ($urandom % 2 != 0) ? 23 : int'($urandom % 24);
    wd = 1 + int'($urandom % 7);
    mo = ($urandom % 3 == 0) ? 12 : 1 + int'($urandom % 12);
    yr = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
    dim = days_in(mo, yr);
    d  = ($urandom % 2 != 0) ? dim : 1 + int'($urandom % dim);
    return pack_time(s, mi, h, wd, d, mo, yr);
  endfunction

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 64'd0, 64'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [55:0] b, rb;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and address map
    read_bank(rb);
    check(rb == 56'h00_01_01_01_00_00_00, "R1", "reset shadow", 64'(rb), 64'h00_01_01_01_00_00_00);
    check(publish == 1'b0, "R1", "reset publish", 64'(publish), 64'd0);
    rd_addr = 3'd7; #0.5;
    check(rd_data == 8'h00, "R1", "address 7 reads zero", 64'(rd_data), 64'd0);
    rd_addr = 3'd0;

    // R9 load leaves shadow untouched; R4 year-end rollover
    b = pack_time(59, 59, 23, 3, 31, 12, 96);
    load_bank(b);
    read_bank(rb);
    check(rb == 56'h00_01_01_01_00_00_00, "R9", "load does not reach shadow", 64'(rb), 64'h00_01_01_01_00_00_00);
    run_tick(b, 1'b0, 0, 0, "R4");

    // R6 seconds only, variable mode
    b = pack_time(10, 5, 7, 2, 14, 6, 30);
    load_bank(b); run_tick(b, 1'b0, 0, 0, "R3");
    // R7 seconds only, fixed mode
    load_bank(b); run_tick(b, 1'b1, 0, 0, "R3");
    // R9 mode sampled at start
    load_bank(b); run_tick(b, 1'b1, 1, 0, "R9");
    b = pack_time(59, 59, 9, 2, 14, 6, 30);
    load_bank(b); run_tick(b, 1'b0, 1, 0, "R9");

    // R5 month ends
    b = pack_time(59, 59, 23, 1, 28, 2, 24); load_bank(b); run_tick(b, 1'b0, 0, 0, "R5");
    b = pack_time(59, 59, 23, 1, 28, 2, 23); load_bank(b); run_tick(b, 1'b0, 0, 0, "R5");
    b = pack_time(59, 59, 23, 1, 29, 2, 24); load_bank(b); run_tick(b, 1'b1, 0, 0, "R5");
    b = pack_time(59, 59, 23, 7, 30, 4, 11); load_bank(b); run_tick(b, 1'b0, 0, 0, "R5");
    b = pack_time(59, 59, 23, 4, 30, 5, 11); load_bank(b); run_tick(b, 1'b0, 0, 0, "R5");
    // R4 weekday 7 -> 1, year 99 -> 00
    b = pack_time(59, 59, 23, 7, 31, 12, 99); load_bank(b); run_tick(b, 1'b0, 0, 0, "R4");
    // R3 minute and hour carries
    b = pack_time(59, 12, 5, 3, 3, 3, 3); load_bank(b); run_tick(b, 1'b0, 0, 0, "R3");
    b = pack_time(59, 59, 5, 3, 3, 3, 3); load_bank(b); run_tick(b, 1'b0, 0, 0, "R3");

    // R2 tick during update ignored
    b = pack_time(20, 20, 20, 5, 20, 8, 50); load_bank(b); run_tick(b, 1'b1, 0, 1, "R2");

    // random mix
    for (int it = 0; it < 40; it++) begin
      b = rand_time();
      load_bank(b);
      run_tick(b, 1'($urandom % 2), 0, 0, "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule